// File: doc/BRIEF.md
# Receiver Byte-Clock Glitch Stretcher

This block turns the receiver's internal byte-boundary pulses into a byte clock and a byte stream for downstream logic. While symbol sync holds, the boundary pulses arrive one byte time apart. Each pulse becomes a falling edge of the output clock. The byte that comes with the pulse is placed on the data output at that same edge. The clock goes back high half a byte time later.

When sync is lost and then regained, the boundary position jumps. A clock that simply followed the boundary pulses would then show a short period. A logic that uses this clock would see it as a glitch. This block keeps a falling edge from coming less than one byte time after the previous one. A boundary that comes too early is held, and it is issued when the byte time has run out. The high phase is stretched by the same amount. A byte still waiting when a newer boundary comes is dropped. The data-valid output is withdrawn across a resync whose boundary has to wait. The sync symbol and every byte after it are delivered in order.

The whole block runs on the oversampling bit clock. After reset it waits for the first sync-reacquired boundary and keeps its clock low until then.

Top module: `bclk_stretch`

## Requirements
- R1: During and just after synchronous reset, `byte_clk`, `data_vld` and `data_out` are all 0.
- R2: Until a boundary pulse arrives with `resync_i` high, boundary pulses are ignored: `byte_clk` and `data_vld` stay low.
- R3: An accepted boundary makes `byte_clk` fall at the same clock edge when at least BYTE_T edges have passed since the previous fall, or when there was no previous fall. Otherwise the fall happens at exactly the BYTE_T-th edge after the previous fall, so two falls are never closer than BYTE_T edges.
- R4: `byte_clk` rises exactly LOW_T = BYTE_T/2 edges after each fall. Every low phase is therefore LOW_T cycles long, and every high phase lasts at least BYTE_T − LOW_T cycles.
- R5: At each fall, `data_out` takes the byte that came on `data_i` with the boundary being issued, and `data_vld` becomes 1.
- R6: `data_vld` goes from 0 to 1 only at a fall of `byte_clk`. `data_out` and `data_vld` change only at a fall or at an accepted resync boundary.
- R7: If a new accepted boundary arrives while an earlier one is still held, the held byte is discarded and never shows on `data_out`. The new boundary follows the timing of R3.
- R8: When a boundary with `resync_i` high is held rather than issued at once, `data_vld` is 0 from the next cycle until that boundary's fall.
- R9: The byte that comes with the resync boundary (the sync symbol), and every later byte, reach `data_out` in arrival order, one per fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_i | input | 1 | One-cycle pulse marking an internal byte boundary |
| resync_i | input | 1 | Qualifies `bnd_i`: this boundary carries the symbol that regained sync |
| data_i | input | DATA_W | Decoded byte, valid in the cycle of `bnd_i` |
| byte_clk | output | 1 | Stretched output byte clock; its falling edge marks a byte |
| data_out | output | DATA_W | Byte issued at the latest falling edge |
| data_vld | output | 1 | `data_out` holds a delivered byte |

## Verification
The assertions assume `bnd_i` is a single-cycle pulse and that `resync_i` is read only in a cycle where `bnd_i` is high. The stimulus drives it that way. While sync holds, the stimulus spaces boundaries exactly BYTE_T cycles apart. At resync points it moves the spacing to short gaps, long gaps and back-to-back early pulses, so that the held-boundary path is exercised. The period and phase checks also assume BYTE_T is at least 4, so that the low phase ends before the next fall can be permitted. The default parameters keep to that.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LIVE = 2'd1,
        SRC_HELD = 2'd2
    } src_e;

    function automatic int unsigned low_len(input int unsigned byte_t);
        return byte_t / 2;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned byte_t);
        return $clog2(byte_t + 1);
    endfunction

endpackage

// File: rtl/bclk_phase.sv
module bclk_phase
    import bclk_pkg::*;
#(
    parameter int unsigned BYTE_T = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    output logic ck_o,
    output logic ready_o
);
    localparam int unsigned LOW_T = low_len(BYTE_T);
    localparam int unsigned CNT_W = cnt_bits(BYTE_T);

    logic [CNT_W-1:0] cnt_q;
    phase_e           ph_q;

    assign ready_o = (cnt_q >= CNT_W'(BYTE_T - 1));
    assign ck_o    = (ph_q == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(BYTE_T);
            ph_q  <= PH_LOW;
        end else if (fall_i) begin
            cnt_q <= '0;
            ph_q  <= PH_LOW;
        end else begin
            if (cnt_q != CNT_W'(BYTE_T))
                cnt_q <= cnt_q + 1'b1;
            if (ph_q == PH_LOW && cnt_q == CNT_W'(LOW_T - 1))
                ph_q <= PH_HIGH;
        end
    end

    // R3: a fall is only requested while the clock is high or never started
    a_r3_fall_from_high: assert property (@(posedge clk) disable iff (rst)
        fall_i |-> (ph_q == PH_HIGH || cnt_q == CNT_W'(BYTE_T)));

endmodule

// File: rtl/bclk_sched.sv
module bclk_sched
    import bclk_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd_i,
    input  logic              resync_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              fall_o,
    output logic [DATA_W-1:0] fall_data_o,
    output logic              rs_bnd_o
);
    logic              synced_q;
    logic              held_q;
    logic [DATA_W-1:0] held_data_q;
    logic              accept;
    src_e              src;

    assign accept   = bnd_i && (synced_q || resync_i);
    assign rs_bnd_o = accept && resync_i;

    always_comb begin
        src = SRC_NONE;
        if (ready_i) begin
            if (accept)
                src = SRC_LIVE;
            else if (held_q)
                src = SRC_HELD;
        end
    end

    assign fall_o      = (src != SRC_NONE);
    assign fall_data_o = (src == SRC_LIVE) ? data_i : held_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            synced_q    <= 1'b0;
            held_q      <= 1'b0;
            held_data_q <= '0;
        end else begin
            if (bnd_i && resync_i)
                synced_q <= 1'b1;
            if (accept && !ready_i) begin
                held_q      <= 1'b1;
                held_data_q <= data_i;
            end else if (fall_o) begin
                held_q <= 1'b0;
            end
        end
    end

    // R2: nothing is issued before the first resync boundary
    a_r2_no_fall_unsynced: assert property (@(posedge clk) disable iff (rst)
        (!synced_q && !(bnd_i && resync_i)) |-> !fall_o);

    // R7: an early boundary arriving over a held one keeps a boundary held
    a_r7_replace_held: assert property (@(posedge clk) disable iff (rst)
        (held_q && accept && !ready_i) |=> (held_q && held_data_q == $past(data_i)));

endmodule

// File: rtl/bclk_outreg.sv
module bclk_outreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic [DATA_W-1:0] fall_data_i,
    input  logic              rs_bnd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              vld_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            vld_o  <= 1'b0;
        end else if (fall_i) begin
            data_o <= fall_data_i;
            vld_o  <= 1'b1;
        end else if (rs_bnd_i) begin
            vld_o  <= 1'b0;
        end
    end

    // R8: a held resync boundary withdraws the valid flag
    a_r8_resync_withdraw: assert property (@(posedge clk) disable iff (rst)
        (rs_bnd_i && !fall_i) |=> !vld_o);

    // R6: outputs are quiet between events
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (!fall_i && !rs_bnd_i) |=> ($stable(data_o) && $stable(vld_o)));

endmodule

// File: rtl/bclk_stretch.sv
module bclk_stretch
    import bclk_pkg::*;
#(
    parameter int unsigned BYTE_T = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd_i,
    input  logic              resync_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              byte_clk,
    output logic [DATA_W-1:0] data_out,
    output logic              data_vld
);
    localparam int unsigned LOW_T = low_len(BYTE_T);
    localparam int unsigned CNT_W = cnt_bits(BYTE_T);

    logic              fall_w;
    logic              ready_w;
    logic              rs_bnd_w;
    logic [DATA_W-1:0] fall_data_w;

    bclk_phase #(.BYTE_T(BYTE_T)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall_w),
        .ck_o    (byte_clk),
        .ready_o (ready_w)
    );

    bclk_sched #(.DATA_W(DATA_W)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .bnd_i       (bnd_i),
        .resync_i    (resync_i),
        .data_i      (data_i),
        .ready_i     (ready_w),
        .fall_o      (fall_w),
        .fall_data_o (fall_data_w),
        .rs_bnd_o    (rs_bnd_w)
    );

    bclk_outreg #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .fall_i      (fall_w),
        .fall_data_i (fall_data_w),
        .rs_bnd_i    (rs_bnd_w),
        .data_o      (data_out),
        .vld_o       (data_vld)
    );

    // Checking state: edges since the last fall, and whether sync was ever seen
    logic [CNT_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= CNT_W'(BYTE_T);
            seen_q <= 1'b0;
        end else begin
            if (bnd_i && resync_i)
                seen_q <= 1'b1;
            if (fall_w)
                gap_q <= '0;
            else if (gap_q != CNT_W'(BYTE_T))
                gap_q <= gap_q + 1'b1;
        end
    end

    a_r3_min_period: assert property (@(posedge clk) disable iff (rst)
        fall_w |-> (gap_q >= CNT_W'(BYTE_T - 1)));

    a_r4_low_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_clk) |-> (gap_q == CNT_W'(LOW_T)));

    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (!byte_clk && !data_vld));

    a_r6_vld_rises_on_fall: assert property (@(posedge clk) disable iff (rst)
        (data_vld && !$past(data_vld)) |-> (gap_q == '0 && !byte_clk));

endmodule

// File: tb/bclk_stretch_test.sv
module bclk_stretch_test;
    localparam int BYTE_T = 10;
    localparam int LOW_T  = BYTE_T / 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bnd = 1'b0;
    logic              rs  = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              byte_clk;
    logic [DATA_W-1:0] data_out;
    logic              data_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bclk_stretch #(.BYTE_T(BYTE_T), .DATA_W(DATA_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .bnd_i    (bnd),
        .resync_i (rs),
        .data_i   (din),
        .byte_clk (byte_clk),
        .data_out (data_out),
        .data_vld (data_vld)
    );

    // Behavioural reference: times of events and a queue for a held byte
    int                now = 0;
    int                last_fall = -1000;
    bit                m_sync = 0;
    logic [DATA_W-1:0] held_q[$];
    logic              e_ck = 0;
    logic              e_v  = 0;
    logic [DATA_W-1:0] e_d  = '0;

    always @(posedge clk) begin
        if (rst) begin
            last_fall = now - 1000;
            m_sync = 0;
            held_q.delete();
            e_ck = 0; e_v = 0; e_d = '0;
        end else begin
            int  since;
            bit  ok, acc, fall;
            logic [DATA_W-1:0] fd;
            since = now - last_fall;
            ok    = (since >= BYTE_T);
            acc   = bnd && (m_sync || rs);
            fall  = 0;
            fd    = '0;
            if (acc) begin
                held_q.delete();
                if (ok) begin fall = 1; fd = din; end
                else held_q.push_back(din);
            end else if (held_q.size() > 0 && ok) begin
                fall = 1; fd = held_q.pop_front();
            end
            if (bnd && rs) m_sync = 1;
            if (fall) begin
                e_ck = 0; last_fall = now; e_d = fd; e_v = 1;
            end else begin
                if (since == LOW_T) e_ck = 1;
                if (acc && rs) e_v = 0;
            end
        end
        now++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(m_sync ? "R3 R4 byte_clk" : "R2 byte_clk", {31'd0, byte_clk}, {31'd0, e_ck});
            chk(m_sync ? "R6 R8 data_vld" : "R2 data_vld", {31'd0, data_vld}, {31'd0, e_v});
            if (e_v) chk("R5 R7 R9 data_out", {24'd0, data_out}, {24'd0, e_d});
        end
    end

    task automatic boundary(input int gap, input bit resync);
        repeat (gap - 1) begin
            @(negedge clk);
            bnd = 0; rs = 0;
        end
        @(negedge clk);
        bnd = 1; rs = resync; din = DATA_W'($urandom);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bnd = 0; rs = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        chk("R1 byte_clk", {31'd0, byte_clk}, 32'd0);
        chk("R1 data_vld", {31'd0, data_vld}, 32'd0);
        chk("R1 data_out", {24'd0, data_out}, 32'd0);
        rst = 0;
        // R2: plain boundaries before sync are ignored
        repeat (4) boundary(BYTE_T, 0);
        // R3 R5: sync, then steady bytes
        boundary(BYTE_T, 1);
        repeat (6) boundary(BYTE_T, 0);
        // R3 R8 R9: early resync is held, latency grows
        boundary(4, 1);
        repeat (5) boundary(BYTE_T, 0);
        // R4: late resync stretches the high phase
        boundary(17, 1);
        repeat (4) boundary(BYTE_T, 0);
        // R7: two early boundaries, first one dropped
        boundary(3, 1);
        boundary(2, 1);
        repeat (4) boundary(BYTE_T, 0);
        // R3: early plain boundary and irregular spacing
        boundary(7, 0);
        repeat (3) boundary(12, 0);
        boundary(1 + BYTE_T / 3, 1);
        boundary(BYTE_T, 0);
        idle(3 * BYTE_T);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule